// File: doc/BRIEF.md
# PCI Master Burst Request Controller

This block runs the bus-request side of a PCI bus master that fetches transmit buffers in bursts. A burst job arrives on a valid/ready interface together with its number of data phases. The block then raises a bus request, waits until the arbiter grants the bus while the bus is idle, and starts exactly one burst in that mastership. For the whole burst it presents the read command code that the burst must use. It counts completed data phases so that it knows when to drop the request and when the burst is over.

Two mode bits shape the burst. The command-select bit picks between Memory Read Line (code 14) and Memory Read Multiple (code 12). The extended-request bit picks when the request is released. With the bit clear, the request drops as soon as the burst starts, and the master relies on the latency timer for bus time. With the bit set, the request stays high until the next-to-last data phase completes, which suits arbiters that never preempt. The mode bits can always be read. They can be written only while the stop or suspend control is set. A soft reset aborts the sequencer but keeps the mode bits.

Job interface rules: `job_ready_o` is high only while the block is idle. A job is taken on a clock edge where `job_valid_i` and `job_ready_o` are both high. A job that is held while `job_ready_o` is low stays pending until the block is idle again. `job_phases_i` is sampled only at the moment of that handshake.

Top module: `pci_burst_req`

## Requirements
- R1: After hard reset `bus_req_o`, `xfer_o` and `burst_done_o` are 0, `cmd_o` is 4'h0, `mode_rd_o` is 2'b00 and `job_ready_o` is 1.
- R2: `mode_wr_i` loads `mode_wdata_i` into the mode bits only when `stop_i` or `suspend_i` is high. Otherwise the mode bits are unchanged. Bit 1 is command select and bit 0 is extended request, and both are always visible on `mode_rd_o`.
- R3: While `xfer_o` is high and command select was 0 at the start of the burst, `cmd_o` is 4'hE (Memory Read Line). Outside a burst `cmd_o` is 4'h0.
- R4: While `xfer_o` is high and command select was 1 at the start of the burst, `cmd_o` is 4'hC (Memory Read Multiple).
- R5: In the cycle after a job handshake, `bus_req_o` is 1 and `job_ready_o` is 0. `bus_req_o` then stays 1 until the burst starts.
- R6: A burst starts on a clock edge where `bus_req_o`, `bus_gnt_i` and `bus_idle_i` are all high. `xfer_o` rises in the next cycle. A grant while the bus is busy does not start it.
- R7: With extended request 0 at the start, `bus_req_o` is 0 from the first cycle of the burst.
- R8: With extended request 1 and at least 2 phases, `bus_req_o` stays 1 through the burst until the next-to-last phase completes, and it is 0 after that. A phase completes on an edge where `irdy_i` and `trdy_i` are both high while `xfer_o` is high.
- R9: With extended request 1 and a single phase, `bus_req_o` is 0 from the first cycle of the burst. A phase count of 0 is treated as 1.
- R10: Exactly one burst is run per mastership. After the last phase completes, `xfer_o` is 0, `burst_done_o` pulses for one cycle, `job_ready_o` returns to 1, and `bus_req_o` stays 0 until a new job handshake.
- R11: `soft_rst_i` returns the block to idle in the next cycle (`bus_req_o` 0, `xfer_o` 0) and leaves the mode bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset of the sequencer, synchronous |
| stop_i | input | 1 | Stop control; opens mode writes |
| suspend_i | input | 1 | Suspend control; opens mode writes |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 2 | Mode write data: [1] command select, [0] extended request |
| mode_rd_o | output | 2 | Current mode bits |
| job_valid_i | input | 1 | Burst job offered |
| job_ready_o | output | 1 | Block idle, job can be taken |
| job_phases_i | input | PH_W | Number of data phases in the job |
| bus_gnt_i | input | 1 | Arbiter grant, active high |
| bus_idle_i | input | 1 | Bus idle, active high |
| irdy_i | input | 1 | Initiator ready for the current phase |
| trdy_i | input | 1 | Target ready for the current phase |
| bus_req_o | output | 1 | Bus request, active high |
| xfer_o | output | 1 | Burst in progress |
| cmd_o | output | 4 | Read command code for the burst |
| burst_done_o | output | 1 | One-cycle pulse after the last phase |

## Verification
The bench targets where the request drops. A design that released it one phase too late or too early with extended request set would show a high or low `bus_req_o` at the phase boundary. A single-phase burst with extended request set goes after a design that waits for a next-to-last phase that never comes and so holds the request through the whole burst. A grant with the bus busy, phases with the target not ready, and a mode write with neither stop nor suspend set check for starts, counts or mode changes that should not happen. The bench also checks that a soft reset in the middle of a request keeps the mode bits and that no second request follows a finished burst.

// File: rtl/pci_burst_req_pkg.sv
package pci_burst_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;

  localparam logic [3:0] CMD_RD_LINE  = 4'hE;
  localparam logic [3:0] CMD_RD_MULTI = 4'hC;
  localparam logic [3:0] CMD_NONE     = 4'h0;

  localparam int MODE_SEL_BIT = 1;
  localparam int MODE_EXT_BIT = 0;
endpackage

// File: rtl/pci_burst_mode_reg.sv
module pci_burst_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic       suspend_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] mode_o
);
  logic wr_open;
  assign wr_open = stop_i | suspend_i;

  // Only hard reset clears the modes; soft reset does not reach this register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_o <= 2'b00;
    else if (wr_i && wr_open) mode_o <= wdata_i;
  end
endmodule

// File: rtl/pci_burst_phase_ctr.sv
module pci_burst_phase_ctr #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PH_W-1:0] phases_i,
  input  logic            dec_i,
  output logic            at_one_o,
  output logic            at_two_o
);
  localparam logic [PH_W-1:0] ONE = PH_W'(1);
  localparam logic [PH_W-1:0] TWO = PH_W'(2);

  logic [PH_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= ONE;
    else if (load_i) left_q <= (phases_i == '0) ? ONE : phases_i;
    else if (dec_i && left_q != ONE) left_q <= left_q - ONE;
  end

  assign at_one_o = (left_q == ONE);
  assign at_two_o = (left_q == TWO);
endmodule

// File: rtl/pci_burst_seq.sv
module pci_burst_seq
  import pci_burst_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst_i,
  input  logic [1:0] mode_i,
  input  logic       job_valid_i,
  input  logic       bus_gnt_i,
  input  logic       bus_idle_i,
  input  logic       phase_done_i,
  input  logic       at_one_i,
  input  logic       at_two_i,
  output logic       job_take_o,
  output logic       idle_o,
  output logic       start_o,
  output logic       xfer_o,
  output logic       req_o,
  output logic [3:0] cmd_o,
  output logic       done_o
);
  seq_state_t state_q;
  logic       req_q, done_q;
  logic [3:0] cmd_q;

  assign idle_o     = (state_q == ST_IDLE);
  assign job_take_o = idle_o & job_valid_i & ~soft_rst_i;
  assign start_o    = (state_q == ST_REQ) & req_q & bus_gnt_i & bus_idle_i & ~soft_rst_i;
  assign xfer_o     = (state_q == ST_XFER);
  assign req_o      = req_q;
  assign cmd_o      = cmd_q;
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      cmd_q   <= CMD_NONE;
      done_q  <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      cmd_q   <= CMD_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (job_take_o) begin
          state_q <= ST_REQ;
          req_q   <= 1'b1;
        end
        ST_REQ: if (start_o) begin
          state_q <= ST_XFER;
          cmd_q   <= mode_i[MODE_SEL_BIT] ? CMD_RD_MULTI : CMD_RD_LINE;
          // Held only when a next-to-last phase exists to release on.
          req_q   <= mode_i[MODE_EXT_BIT] & ~at_one_i;
        end
        ST_XFER: if (phase_done_i) begin
          if (at_one_i) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            cmd_q   <= CMD_NONE;
            done_q  <= 1'b1;
          end else if (at_two_i) begin
            req_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_burst_req.sv
module pci_burst_req
  import pci_burst_req_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst_i,
  input  logic            stop_i,
  input  logic            suspend_i,
  input  logic            mode_wr_i,
  input  logic [1:0]      mode_wdata_i,
  output logic [1:0]      mode_rd_o,
  input  logic            job_valid_i,
  output logic            job_ready_o,
  input  logic [PH_W-1:0] job_phases_i,
  input  logic            bus_gnt_i,
  input  logic            bus_idle_i,
  input  logic            irdy_i,
  input  logic            trdy_i,
  output logic            bus_req_o,
  output logic            xfer_o,
  output logic [3:0]      cmd_o,
  output logic            burst_done_o
);
  logic [1:0] mode;
  logic       job_take, seq_idle, start, phase_done, at_one, at_two;

  pci_burst_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop_i),
    .suspend_i (suspend_i),
    .wr_i      (mode_wr_i),
    .wdata_i   (mode_wdata_i),
    .mode_o    (mode)
  );

  assign phase_done = xfer_o & irdy_i & trdy_i;

  pci_burst_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (job_take),
    .phases_i (job_phases_i),
    .dec_i    (phase_done),
    .at_one_o (at_one),
    .at_two_o (at_two)
  );

  pci_burst_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .mode_i       (mode),
    .job_valid_i  (job_valid_i),
    .bus_gnt_i    (bus_gnt_i),
    .bus_idle_i   (bus_idle_i),
    .phase_done_i (phase_done),
    .at_one_i     (at_one),
    .at_two_i     (at_two),
    .job_take_o   (job_take),
    .idle_o       (seq_idle),
    .start_o      (start),
    .xfer_o       (xfer_o),
    .req_o        (bus_req_o),
    .cmd_o        (cmd_o),
    .done_o       (burst_done_o)
  );

  assign job_ready_o = seq_idle;
  assign mode_rd_o   = mode;

  // The start strobe is consumed inside the sequencer only.
  logic unused_start;
  assign unused_start = start;
endmodule

// File: rtl/pci_burst_req_chk.sv
module pci_burst_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst_i,
  input logic       stop_i,
  input logic       suspend_i,
  input logic       mode_wr_i,
  input logic [1:0] mode_rd_o,
  input logic       bus_gnt_i,
  input logic       bus_idle_i,
  input logic       job_ready_o,
  input logic       bus_req_o,
  input logic       xfer_o,
  input logic [3:0] cmd_o,
  input logic       burst_done_o
);
  p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr_i && (stop_i || suspend_i)) |=> $stable(mode_rd_o));

  p_cmd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> (cmd_o == 4'hE || cmd_o == 4'hC));

  p_cmd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_o |-> cmd_o == 4'h0);

  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !xfer_o && !(bus_gnt_i && bus_idle_i) && !soft_rst_i) |=> bus_req_o);

  p_start_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_o && !(bus_req_o && bus_gnt_i && bus_idle_i)) |=> !xfer_o);

  p_ext_clear_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xfer_o) && !$past(mode_rd_o[0])) |-> !bus_req_o);

  p_ready_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready_o |-> (!bus_req_o && !xfer_o));

  p_done_ends_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done_o |-> (!xfer_o && !bus_req_o && job_ready_o));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!bus_req_o && !xfer_o));
endmodule

bind pci_burst_req pci_burst_req_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst_i   (soft_rst_i),
  .stop_i       (stop_i),
  .suspend_i    (suspend_i),
  .mode_wr_i    (mode_wr_i),
  .mode_rd_o    (mode_rd_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_idle_i   (bus_idle_i),
  .job_ready_o  (job_ready_o),
  .bus_req_o    (bus_req_o),
  .xfer_o       (xfer_o),
  .cmd_o        (cmd_o),
  .burst_done_o (burst_done_o)
);

// File: tb/test_pci_burst_req.sv
`timescale 1ns/1ps
module test_pci_burst_req;
  localparam int PH_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 0, stop_i = 0, suspend_i = 0, mode_wr_i = 0;
  logic [1:0] mode_wdata_i = 2'b00;
  logic [1:0] mode_rd_o;
  logic job_valid_i = 0, job_ready_o;
  logic [PH_W-1:0] job_phases_i = '0;
  logic bus_gnt_i = 0, bus_idle_i = 1, irdy_i = 0, trdy_i = 0;
  logic bus_req_o, xfer_o, burst_done_o;
  logic [3:0] cmd_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pci_burst_req #(.PH_W(PH_W)) i_pci_burst_req (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "req", bus_req_o, 0);
    chk("R1", "xfer", xfer_o, 0);
    chk("R1", "done", burst_done_o, 0);
    chk("R1", "cmd", cmd_o, 0);
    chk("R1", "mode", mode_rd_o, 0);
    chk("R1", "ready", job_ready_o, 1);
  endtask

  task automatic mode_write(input logic [1:0] v, input logic st, input logic sp, input logic [1:0] exp);
    stop_i = st; suspend_i = sp; mode_wdata_i = v; mode_wr_i = 1;
    cyc();
    mode_wr_i = 0; stop_i = 0; suspend_i = 0;
    chk("R2", "mode after write", mode_rd_o, exp);
  endtask

  // One full burst; checks request, start, command, release point and end.
  task automatic run_burst(input int n, input bit sel, input bit ext);
    int eff = (n == 0) ? 1 : n;
    job_valid_i = 1; job_phases_i = PH_W'(n);
    chk("R10", "ready before job", job_ready_o, 1);
    cyc();
    job_valid_i = 0;
    chk("R5", "req after handshake", bus_req_o, 1);
    chk("R5", "ready low", job_ready_o, 0);
    // grant while bus busy: no start
    bus_gnt_i = 1; bus_idle_i = 0;
    cyc();
    chk("R6", "no start on busy bus", xfer_o, 0);
    chk("R5", "req held", bus_req_o, 1);
    bus_idle_i = 1;
    cyc();
    bus_gnt_i = 0;
    chk("R6", "xfer after start", xfer_o, 1);
    chk(sel ? "R4" : "R3", "cmd", cmd_o, sel ? 12 : 14);
    if (!ext) chk("R7", "req at start", bus_req_o, 0);
    else if (eff == 1) chk("R9", "req at start", bus_req_o, 0);
    else chk("R8", "req at start", bus_req_o, 1);
    for (int k = 1; k <= eff; k++) begin
      // one wait state: target not ready, nothing completes
      irdy_i = 1; trdy_i = 0;
      cyc();
      chk("R8", "wait keeps xfer", xfer_o, 1);
      trdy_i = 1;
      cyc();
      irdy_i = 0; trdy_i = 0;
      if (k < eff) begin
        chk("R8", "xfer mid burst", xfer_o, 1);
        chk(ext ? "R8" : "R7", "req mid burst", bus_req_o, (ext && k < eff - 1) ? 1 : 0);
      end
    end
    chk("R10", "xfer ended", xfer_o, 0);
    chk("R10", "done pulse", burst_done_o, 1);
    chk("R3", "cmd idle", cmd_o, 0);
    bus_gnt_i = 1;
    cyc();
    cyc();
    bus_gnt_i = 0;
    chk("R10", "done one cycle", burst_done_o, 0);
    chk("R10", "no re-request", bus_req_o, 0);
    chk("R10", "no second burst", xfer_o, 0);
    chk("R10", "ready again", job_ready_o, 1);
  endtask

  task automatic t_soft_reset();
    job_valid_i = 1; job_phases_i = 8'd3;
    cyc();
    job_valid_i = 0;
    chk("R11", "req before soft reset", bus_req_o, 1);
    soft_rst_i = 1;
    cyc();
    soft_rst_i = 0;
    chk("R11", "req after soft reset", bus_req_o, 0);
    chk("R11", "xfer after soft reset", xfer_o, 0);
    chk("R11", "mode kept", mode_rd_o, 3);
    chk("R11", "ready after soft reset", job_ready_o, 1);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    mode_write(2'b11, 0, 0, 2'b00);            // R2 locked
    mode_write(2'b10, 1, 0, 2'b10);            // R2 via stop
    mode_write(2'b01, 0, 1, 2'b01);            // R2 via suspend
    mode_write(2'b00, 1, 1, 2'b00);
    run_burst(4, 0, 0);                        // R3, R7
    mode_write(2'b11, 1, 0, 2'b11);
    run_burst(4, 1, 1);                        // R4, R8
    run_burst(2, 1, 1);                        // R8 shortest
    run_burst(1, 1, 1);                        // R9
    run_burst(0, 1, 1);                        // R9 zero as one
    mode_write(2'b01, 0, 1, 2'b01);
    run_burst(3, 0, 1);                        // R3 with ext
    mode_write(2'b11, 1, 0, 2'b11);
    t_soft_reset();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule